// File: doc/BRIEF.md
# Scalar Load/Store Lane Formatter

This block is one pipeline stage that sits between instruction decode and a big-endian, 32-bit-wide data memory. It takes an instruction word for a scalar byte, halfword or word access, together with the base-register and source-register values. From these it builds a memory request: the effective address, the store data moved into its byte lanes, a bit-level write mask, and the destination register index. The request is registered, so the memory sees it one cycle after the instruction is presented.

A 3-bit access index in the instruction word selects the access size, the signedness and the read mask. Its low two bits give a size code. The shift amount, (3 − size) × 8 bits, is computed once. It places store data toward the most significant lane, and the same shift brings load data back down. On the return side the memory word is shifted right arithmetically by the registered amount and then ANDed with the registered read mask. This produces the value to write back, either sign-extended or zero-extended. Memory protection, misalignment faults and wrap within a word are left to other blocks.

Top module: `scalar_lane_fmt`

## Requirements
- R1: While reset is asserted, and on the first cycles after reset, `req_valid` is 0 and `req_wmask` is zero.
- R2: `req_addr` equals `in_base` plus the sign-extended `in_instr[15:0]`, modulo 2^32. The sum wraps and no carry out is kept.
- R3: The access index is `in_instr[28:26]`. Its bits [1:0] form the size code (0 byte, 1 halfword, 2 three bytes, 3 word), and the lane shift is (3 − size code) × 8 bits.
- R4: For a store, `req_wdata` is `in_src` shifted left by the lane shift. For example, size code 0 gives `{in_src[7:0], 24'h0}`.
- R5: `req_wmask` is all-ones shifted left by the lane shift when `in_instr[29]` is 1 (store). It is zero when `in_instr[29]` is 0 (load).
- R6: `req_dest` is `in_instr[20:16]` for a load and 0 for a store.
- R7: The read mask per access index is all-ones for 0–3, 0x000000FF for 4, 0x0000FFFF for 5, zero for 6, and all-ones for 7.
- R8: `ld_value` is `rd_data` shifted right arithmetically by the registered lane shift, then ANDed with the registered read mask. For example, index 0 gives the top byte of `rd_data` sign-extended.
- R9: A request captured while `in_valid` is 1 appears on the `req_*` ports on the next clock edge, with `req_valid` set to 1. While `in_valid` is 0, `req_valid` drops to 0 and the other `req_*` fields keep their values.
- R10: `req_store` carries `in_instr[29]` of the captured instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Instruction word |
| in_base | input | 32 | Base register value |
| in_src | input | 32 | Store source register value |
| rd_data | input | 32 | Word returned by memory for the registered request |
| req_valid | output | 1 | Registered request valid |
| req_addr | output | 32 | Effective byte address |
| req_wdata | output | 32 | Store data placed in its lanes |
| req_wmask | output | 32 | Bit write mask, zero for loads |
| req_store | output | 1 | Request is a store |
| req_dest | output | 5 | Register to write back, zero for stores |
| ld_value | output | 32 | Aligned and extended load result |

## Verification
Every cycle, the assertions check the timing of the valid flag and how the registered fields hold while the stage is idle. They also check two rules: a load never carries a write mask, and a store never names a destination register. A further check requires every store mask to cover the most significant lane. The exact lane placement of store data, the mask for each size, the address arithmetic including wrap, and the extension of returned data are value mappings. These can only be shown by the bench's directed scenarios, which walk all eight access indices with loads and stores and use returned words with both sign bits.

// File: rtl/slf_pkg.sv
package slf_pkg;
    localparam int BYTE_W    = 8;
    localparam int INSTR_W   = 32;
    localparam int IDX_LSB   = 26;
    localparam int IDX_W     = 3;
    localparam int STORE_BIT = 29;
    localparam int RT_LSB    = 16;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_TRIPLE = 2'd2,
        SZ_WORD   = 2'd3
    } size_e;
endpackage

// File: rtl/slf_decode.sv
module slf_decode
    import slf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] rmask,
    output logic [DATA_W-1:0] wmask_full
);
    localparam int LANES = DATA_W / BYTE_W;

    size_e size;

    always_comb begin
        size       = size_e'(idx[1:0]);
        shamt      = SH_W'((LANES - 1 - int'(idx[1:0])) * BYTE_W);
        wmask_full = {DATA_W{1'b1}} << shamt;
        if (!idx[2]) begin
            rmask = {DATA_W{1'b1}};
        end else begin
            unique case (size)
                SZ_BYTE:   rmask = DATA_W'({BYTE_W{1'b1}});
                SZ_HALF:   rmask = DATA_W'({(2*BYTE_W){1'b1}});
                SZ_TRIPLE: rmask = '0;
                default:   rmask = {DATA_W{1'b1}};
            endcase
        end
    end
endmodule

// File: rtl/slf_request.sv
module slf_request
    import slf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int RIDX_W = 5,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  base,
    input  logic [DATA_W-1:0]  src,
    input  logic [SH_W-1:0]    shamt,
    input  logic [DATA_W-1:0]  wmask_full,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  wmask,
    output logic               is_store,
    output logic [RIDX_W-1:0]  dest
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset   = {{(ADDR_W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
        addr     = base + offset;
        is_store = instr[STORE_BIT];
        wdata    = src << shamt;
        wmask    = is_store ? wmask_full : '0;
        dest     = is_store ? '0 : instr[RT_LSB +: RIDX_W];
    end
endmodule

// File: rtl/slf_extract.sv
module slf_extract #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] rmask,
    output logic [DATA_W-1:0] value
);
    logic signed [DATA_W-1:0] word_s;
    logic signed [DATA_W-1:0] shifted;

    always_comb begin
        word_s  = rdata;
        shifted = word_s >>> shamt;
        value   = shifted & rmask;
    end
endmodule

// File: rtl/scalar_lane_fmt.sv
module scalar_lane_fmt
    import slf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int RIDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        in_instr,
    input  logic [ADDR_W-1:0]  in_base,
    input  logic [DATA_W-1:0]  in_src,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  req_wmask,
    output logic               req_store,
    output logic [RIDX_W-1:0]  req_dest,
    output logic [DATA_W-1:0]  ld_value
);
    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic              store;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] wmask;
        logic [DATA_W-1:0] rmask;
        logic [SH_W-1:0]   shamt;
        logic [RIDX_W-1:0] dest;
    } req_t;

    req_t req_d, req_q;

    logic [SH_W-1:0]   dec_shamt;
    logic [DATA_W-1:0] dec_rmask;
    logic [DATA_W-1:0] dec_wmask_full;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    logic [DATA_W-1:0] rq_wmask;
    logic              rq_store;
    logic [RIDX_W-1:0] rq_dest;

    slf_decode #(.DATA_W(DATA_W)) u_decode (
        .idx        (in_instr[IDX_LSB +: IDX_W]),
        .shamt      (dec_shamt),
        .rmask      (dec_rmask),
        .wmask_full (dec_wmask_full)
    );

    slf_request #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .RIDX_W(RIDX_W)
    ) u_request (
        .instr      (in_instr),
        .base       (in_base),
        .src        (in_src),
        .shamt      (dec_shamt),
        .wmask_full (dec_wmask_full),
        .addr       (rq_addr),
        .wdata      (rq_wdata),
        .wmask      (rq_wmask),
        .is_store   (rq_store),
        .dest       (rq_dest)
    );

    // next-state: capture only when an instruction is present
    always_comb begin
        req_d       = req_q;
        req_d.valid = in_valid;
        if (in_valid) begin
            req_d.store = rq_store;
            req_d.addr  = rq_addr;
            req_d.wdata = rq_wdata;
            req_d.wmask = rq_wmask;
            req_d.rmask = dec_rmask;
            req_d.shamt = dec_shamt;
            req_d.dest  = rq_dest;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    slf_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata (rd_data),
        .shamt (req_q.shamt),
        .rmask (req_q.rmask),
        .value (ld_value)
    );

    assign req_valid = req_q.valid;
    assign req_addr  = req_q.addr;
    assign req_wdata = req_q.wdata;
    assign req_wmask = req_q.wmask;
    assign req_store = req_q.store;
    assign req_dest  = req_q.dest;

    // R9: presented one cycle after capture
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> req_valid);
    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !req_valid);
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(req_addr) && $stable(req_wdata) && $stable(req_dest)));
    // R10: direction flag travels with the request
    assert_store_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (req_store == $past(in_instr[STORE_BIT])));
    // R5: loads never write, stores always cover the top lane
    assert_load_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |-> (req_wmask == '0));
    assert_store_toplane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |-> req_wmask[DATA_W-1]);
    // R6: stores name no destination register
    assert_store_nodest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |-> (req_dest == '0));
endmodule

// File: tb/scalar_lane_fmt_test.sv
module scalar_lane_fmt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_base = '0;
    logic [31:0] in_src = '0;
    logic [31:0] rd_data = '0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [31:0] req_wmask;
    logic        req_store;
    logic [4:0]  req_dest;
    logic [31:0] ld_value;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    scalar_lane_fmt uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_base(in_base), .in_src(in_src), .rd_data(rd_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .req_store(req_store), .req_dest(req_dest),
        .ld_value(ld_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_load(input logic [2:0] idx, input logic [31:0] d);
        case (idx)
            3'd0: return {{24{d[31]}}, d[31:24]};
            3'd1: return {{16{d[31]}}, d[31:16]};
            3'd2: return {{8{d[31]}}, d[31:8]};
            3'd4: return {24'h0, d[31:24]};
            3'd5: return {16'h0, d[31:16]};
            3'd6: return 32'h0;
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [31:0] s);
        case (sz)
            2'd0: return {s[7:0], 24'h0};
            2'd1: return {s[15:0], 16'h0};
            2'd2: return {s[23:0], 8'h0};
            default: return s;
        endcase
    endfunction

    function automatic logic [31:0] exp_wmask(input logic [1:0] sz);
        case (sz)
            2'd0: return 32'hFF00_0000;
            2'd1: return 32'hFFFF_0000;
            2'd2: return 32'hFFFF_FF00;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // drive at a falling edge, leave the captured request visible at the next falling edge
    task automatic issue(input logic st, input logic [2:0] idx, input logic [4:0] rt,
                         input logic [15:0] imm, input logic [31:0] base, input logic [31:0] src);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = {2'b00, st, idx, 5'd3, rt, imm};
        in_base  = base;
        in_src   = src;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'h0, req_valid}, 32'h0);
        chk("R1 wmask in reset", req_wmask, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'h0, req_valid}, 32'h0);
    endtask

    task automatic t_loads();
        logic [31:0] pats [2];
        pats[0] = 32'h80FF_7F01;
        pats[1] = 32'h7F00_1234;
        for (int i = 0; i < 8; i++) begin
            issue(1'b0, 3'(i), 5'(i + 8), 16'h0010, 32'h0000_1000, 32'hDEAD_BEEF);
            chk("R9 load valid", {31'h0, req_valid}, 32'h1);
            chk("R2 load addr", req_addr, 32'h0000_1010);
            chk("R5 load wmask zero", req_wmask, 32'h0);
            chk("R6 load dest", {27'h0, req_dest}, 32'(i + 8));
            chk("R10 load flag", {31'h0, req_store}, 32'h0);
            for (int p = 0; p < 2; p++) begin
                rd_data = pats[p];
                #1;
                chk((i < 4) ? "R8 load extend" : "R7 load mask", ld_value,
                    exp_load(3'(i), pats[p]));
            end
        end
    endtask

    task automatic t_stores();
        for (int i = 0; i < 8; i++) begin
            issue(1'b1, 3'(i), 5'd17, 16'hFFF0, 32'h0000_0200, 32'hA1B2_C3D4);
            chk("R2 store addr negative offset", req_addr, 32'h0000_01F0);
            chk("R3 R4 store data lanes", req_wdata, exp_wdata(2'(i), 32'hA1B2_C3D4));
            chk("R5 store wmask", req_wmask, exp_wmask(2'(i)));
            chk("R6 store dest zero", {27'h0, req_dest}, 32'h0);
            chk("R10 store flag", {31'h0, req_store}, 32'h1);
        end
    endtask

    task automatic t_addr_wrap();
        issue(1'b0, 3'd3, 5'd1, 16'h0010, 32'hFFFF_FFF8, 32'h0);
        chk("R2 wrap past top", req_addr, 32'h0000_0008);
        issue(1'b0, 3'd3, 5'd1, 16'h8000, 32'h0000_0000, 32'h0);
        chk("R2 most negative offset", req_addr, 32'hFFFF_8000);
    endtask

    task automatic t_hold();
        issue(1'b0, 3'd1, 5'd9, 16'h0004, 32'h0000_3000, 32'h0);
        in_instr = {2'b00, 1'b1, 3'd3, 5'd3, 5'd2, 16'h0100};
        in_base  = 32'h0000_7000;
        in_src   = 32'h1234_5678;
        @(negedge clk);
        chk("R9 idle clears valid", {31'h0, req_valid}, 32'h0);
        chk("R9 idle holds addr", req_addr, 32'h0000_3004);
        chk("R9 idle holds dest", {27'h0, req_dest}, 32'd9);
        chk("R9 idle holds wmask", req_wmask, 32'h0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = {2'b00, 1'b1, 3'd1, 5'd3, 5'd4, 16'h0002};
        in_base  = 32'h0000_0100;
        in_src   = 32'h0000_BEEF;
        @(negedge clk);
        chk("R9 first of pair addr", req_addr, 32'h0000_0102);
        chk("R4 first of pair data", req_wdata, 32'hBEEF_0000);
        in_instr = {2'b00, 1'b0, 3'd4, 5'd3, 5'd6, 16'h0003};
        in_base  = 32'h0000_0200;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 second of pair valid", {31'h0, req_valid}, 32'h1);
        chk("R9 second of pair addr", req_addr, 32'h0000_0203);
        chk("R6 second of pair dest", {27'h0, req_dest}, 32'd6);
        rd_data = 32'hC3FF_FFFF;
        #1;
        chk("R7 unsigned byte return", ld_value, 32'h0000_00C3);
    endtask

    initial begin
        t_reset();
        t_loads();
        t_stores();
        t_addr_wrap();
        t_hold();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule